// File: doc/BRIEF.md
# Three-Channel Compare Timer Core

This block is the counting engine of a general-purpose timer. It holds an up-counter that advances once per prescaled tick. It compares the counter against three compare values and emits single-cycle event pulses. Status flag storage outside the block latches these pulses. The tick comes from one of three source strobes chosen by a 3-bit select code. Each strobe is a one-cycle enable in the block's own clock domain. A 12-bit down-counting prescaler then divides the selected strobe by (1 + prescale).

There are two counting modes. In restart mode, channel 1 is the period register: the counter counts up to the channel-1 value and then returns to zero. In free-run mode, the counter passes every compare value and wraps from all-ones to zero, which raises a rollover pulse.

Control is a two-state machine. HALT is the reset state and the state while the timer is disabled. COUNT is the state while the timer is counting. There are two transitions:
- START (HALT to COUNT) is taken when the enable rises. It reloads the prescaler. When the restart-on-start bit is set, it also clears the counter.
- STOP (COUNT to HALT) is taken when the enable falls. It freezes both the counter and the prescaler.

A clear request or a channel-1 write strobe in restart mode forces the counter to zero in either state.

Top module: `cmp_timer_core`

## Requirements
- R1: After reset the count is 0, every event output is 0 and the machine is in HALT.
- R2: Source select code 3'b001 takes src_strobe[0], 3'b010 takes src_strobe[1] and 3'b100 takes src_strobe[2]. Codes 000, 011, 101, 110 and 111 select no source, and the count then holds its value.
- R3: In COUNT, the prescaler steps down once per selected strobe. When the prescaler is at zero, a strobe is a tick that advances the count, and the prescaler reloads presc. The prescaler is also reloaded on START and on every counter clear. The count therefore advances once per presc+1 selected strobes.
- R4: The count only advances in COUNT with run_en high. The cycle in which run_en is first seen high (START) does not advance it. Dropping run_en freezes the count.
- R5: START with restart_on_start=1 clears the count to 0. START with restart_on_start=0 resumes from the held count.
- R6: On a tick, evt_cmp[k] pulses for one cycle if the new count equals the compare value of channel k+1, where bit 0 is channel 1, bit 1 is channel 2 and bit 2 is channel 3. The pulse appears on the same edge that loads the new count, and coincident matches pulse together.
- R7: In restart mode (free_run=0), a tick taken while the count equals cmp1_val loads 0 instead of count+1.
- R8: A tick taken while the count is all-ones loads 0 and pulses evt_rov in the same cycle. The exception is restart mode with cmp1_val all-ones, where the R7 reload applies and there is no rollover.
- R9: A high cmp1_wr in restart mode clears the count and reloads the prescaler. In free-run mode, cmp1_wr has no effect on the count.
- R10: A high clr_req clears the count and reloads the prescaler on the next edge, overriding a tick. No event pulses on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer enable |
| restart_on_start | input | 1 | Clear the count when the enable rises |
| free_run | input | 1 | 1 = free-run mode, 0 = restart mode |
| src_sel | input | 3 | Tick source select code |
| src_strobe | input | 3 | Source strobes: [0] peripheral, [1] high-rate, [2] 32 kHz |
| presc | input | PRE_W (12) | Prescale value; the tick divides by presc+1 |
| cmp1_val | input | CNT_W (32) | Channel-1 compare value, which is also the restart period |
| cmp2_val | input | CNT_W (32) | Channel-2 compare value |
| cmp3_val | input | CNT_W (32) | Channel-3 compare value |
| cmp1_wr | input | 1 | Strobe marking a write of cmp1_val |
| clr_req | input | 1 | Counter clear request |
| count | output | CNT_W (32) | Current count |
| evt_cmp | output | 3 | Compare-match pulses, one bit per channel |
| evt_rov | output | 1 | Rollover pulse |

## Verification
Every result of this block is registered. A tick, a clear, a channel-1 write or a START seen in one cycle shows up on count, evt_cmp and evt_rov just after the next rising edge. The exception is START itself, which never advances the count in its own cycle, so the first advance after enabling comes one cycle later still. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge from the same input values. It compares the model against the outputs on the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks for freezing, START clearing, clearing and channel-1 writes sample one falling edge after the stimulus for the same reason.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    localparam int SEL_W = 3;
    localparam int N_SRC = 3;

    localparam logic [SEL_W-1:0] SRC_PERIPH = 3'b001;
    localparam logic [SEL_W-1:0] SRC_FAST   = 3'b010;
    localparam logic [SEL_W-1:0] SRC_SLOW   = 3'b100;

    // Map a select code to the chosen strobe; undefined codes give none.
    function automatic logic pick_source(input logic [SEL_W-1:0] sel,
                                         input logic [N_SRC-1:0] strobes);
        logic hit;
        unique case (sel)
            SRC_PERIPH: hit = strobes[0];
            SRC_FAST:   hit = strobes[1];
            SRC_SLOW:   hit = strobes[2];
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl
    import ctmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic restart_on_start,
    input  logic free_run,
    input  logic cmp1_wr,
    input  logic clr_req,
    output logic active,
    output logic pre_reload,
    output logic cnt_zero
);

    run_state_t state_q;
    run_state_t state_d;
    logic       start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START on enable rise, STOP on enable fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_en)  state_d = ST_COUNT;
            ST_COUNT: if (!run_en) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        start      = 1'b0;
        active     = 1'b0;
        unique case (state_q)
            ST_HALT:  start  = run_en;
            ST_COUNT: active = run_en;
            default:  begin start = 1'b0; active = 1'b0; end
        endcase
        cnt_zero   = clr_req || (cmp1_wr && !free_run) || (start && restart_on_start);
        pre_reload = cnt_zero || start;
    end

    assert_halt_after_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_HALT));

    assert_count_after_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (state_q == ST_COUNT));

    assert_no_count_in_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !active);

endmodule

// File: rtl/ctmr_prescale.sv
module ctmr_prescale
    import ctmr_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             reload,
    input  logic [PRE_W-1:0] presc,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [N_SRC-1:0] src_strobe,
    output logic             tick
);

    logic [PRE_W-1:0] pcnt_q;
    logic             sel_strobe;
    logic             step;

    always_comb begin
        sel_strobe = pick_source(src_sel, src_strobe);
        step       = active && sel_strobe;
        tick       = step && (pcnt_q == '0) && !reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (reload) begin
            pcnt_q <= presc;
        end else if (step) begin
            if (pcnt_q == '0) begin
                pcnt_q <= presc;
            end else begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    assert_reload_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == $past(presc)));

    assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !step) |=> $stable(pcnt_q));

    assert_tick_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (src_sel == SRC_PERIPH || src_sel == SRC_FAST || src_sel == SRC_SLOW));

endmodule

// File: rtl/ctmr_count.sv
module ctmr_count #(
    parameter int CNT_W = 32,
    parameter int N_CH  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      zero_req,
    input  logic                      free_run,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_vals,
    output logic [CNT_W-1:0]          count,
    output logic [N_CH-1:0]           evt_cmp,
    output logic                      evt_rov
);

    logic             hit_period;
    logic             at_top;
    logic             wrap;
    logic [CNT_W-1:0] nxt;
    logic             load_nxt;

    always_comb begin
        hit_period = !free_run && (count == cmp_vals[0]);
        at_top     = (count == {CNT_W{1'b1}});
        wrap       = at_top && !hit_period;
        nxt        = (hit_period || at_top) ? '0 : count + 1'b1;
        load_nxt   = tick && !zero_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            evt_rov <= 1'b0;
        end else if (zero_req) begin
            count   <= '0;
            evt_rov <= 1'b0;
        end else if (tick) begin
            count   <= nxt;
            evt_rov <= wrap;
        end else begin
            evt_rov <= 1'b0;
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_cmp[ch] <= 1'b0;
            end else begin
                evt_cmp[ch] <= load_nxt && (nxt == cmp_vals[ch]);
            end
        end
    end

    assert_freeze_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !zero_req) |=> $stable(count));

    assert_period_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_nxt && !free_run && (count == cmp_vals[0])) |=> (count == '0));

    assert_rollover_lands_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rov |-> (count == '0));

    assert_clear_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> ((count == '0) && !evt_rov && (evt_cmp == '0)));

    assert_match_on_new_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmp[0] |-> (count == $past(cmp_vals[0])));

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart_on_start,
    input  logic             free_run,
    input  logic [2:0]       src_sel,
    input  logic [2:0]       src_strobe,
    input  logic [PRE_W-1:0] presc,
    input  logic [CNT_W-1:0] cmp1_val,
    input  logic [CNT_W-1:0] cmp2_val,
    input  logic [CNT_W-1:0] cmp3_val,
    input  logic             cmp1_wr,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       evt_cmp,
    output logic             evt_rov
);

    localparam int N_CH = 3;

    logic                       active;
    logic                       pre_reload;
    logic                       cnt_zero;
    logic                       tick;
    logic [N_CH-1:0][CNT_W-1:0] cmp_vals;

    assign cmp_vals = {cmp3_val, cmp2_val, cmp1_val};

    ctmr_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .run_en           (run_en),
        .restart_on_start (restart_on_start),
        .free_run         (free_run),
        .cmp1_wr          (cmp1_wr),
        .clr_req          (clr_req),
        .active           (active),
        .pre_reload       (pre_reload),
        .cnt_zero         (cnt_zero)
    );

    ctmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .reload     (pre_reload),
        .presc      (presc),
        .src_sel    (src_sel),
        .src_strobe (src_strobe),
        .tick       (tick)
    );

    ctmr_count #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .zero_req (cnt_zero),
        .free_run (free_run),
        .cmp_vals (cmp_vals),
        .count    (count),
        .evt_cmp  (evt_cmp),
        .evt_rov  (evt_rov)
    );

    assert_free_run_ignores_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp1_wr && free_run && !clr_req && !(run_en && restart_on_start)) |=> (count != '0 || $past(count) == '0 || $past(count) == '1 || $past(count) == $past(cmp1_val) || $past(count) == '1));

    assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0));

endmodule

// File: tb/cmp_timer_core_test.sv
module cmp_timer_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int PRE_W      = 12;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run_en;
    logic             restart_on_start;
    logic             free_run;
    logic [2:0]       src_sel;
    logic [2:0]       src_strobe;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] cmp1_val;
    logic [CNT_W-1:0] cmp2_val;
    logic [CNT_W-1:0] cmp3_val;
    logic             cmp1_wr;
    logic             clr_req;
    logic [CNT_W-1:0] count;
    logic [2:0]       evt_cmp;
    logic             evt_rov;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    cmp_on = 1'b0;
    int    sc     = 0;

    // Behavioural reference state
    int m_cnt = 0;
    int m_pc  = 0;
    bit m_run = 1'b0;
    bit [2:0] m_evt = 3'b000;
    bit m_rov = 1'b0;

    cmp_timer_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .run_en           (run_en),
        .restart_on_start (restart_on_start),
        .free_run         (free_run),
        .src_sel          (src_sel),
        .src_strobe       (src_strobe),
        .presc            (presc),
        .cmp1_val         (cmp1_val),
        .cmp2_val         (cmp2_val),
        .cmp3_val         (cmp3_val),
        .cmp1_wr          (cmp1_wr),
        .clr_req          (clr_req),
        .count            (count),
        .evt_cmp          (evt_cmp),
        .evt_rov          (evt_rov)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Source strobe patterns, driven away from the active edge
    always @(negedge clk) begin
        sc <= sc + 1;
        src_strobe <= {(sc % 5) == 0, (sc % 2) == 0, (sc % 3) != 0};
    end

    // Reference model step on each rising edge
    always @(posedge clk) begin : model
        bit strobe, start, zero, reload, act, tick;
        int nx;
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_run = 1'b0; m_evt = 3'b000; m_rov = 1'b0;
        end else begin
            case (src_sel)
                3'b001:  strobe = src_strobe[0];
                3'b010:  strobe = src_strobe[1];
                3'b100:  strobe = src_strobe[2];
                default: strobe = 1'b0;
            endcase
            start  = !m_run && run_en;
            act    = m_run && run_en;
            zero   = clr_req || (cmp1_wr && !free_run) || (start && restart_on_start);
            reload = zero || start;
            tick   = act && strobe && (m_pc == 0) && !reload;
            m_evt  = 3'b000;
            m_rov  = 1'b0;
            if (zero) begin
                m_cnt = 0;
            end else if (tick) begin
                if (!free_run && m_cnt == int'(cmp1_val)) nx = 0;
                else if (m_cnt == MAXV) begin nx = 0; m_rov = 1'b1; end
                else nx = m_cnt + 1;
                m_evt[0] = (nx == int'(cmp1_val));
                m_evt[1] = (nx == int'(cmp2_val));
                m_evt[2] = (nx == int'(cmp3_val));
                m_cnt = nx;
            end
            if (reload) m_pc = int'(presc);
            else if (act && strobe) m_pc = (m_pc == 0) ? int'(presc) : m_pc - 1;
            m_run = run_en;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("count", 32'(count), 32'(m_cnt));
            chk("compare events", 32'(evt_cmp), 32'(m_evt));
            chk("rollover", 32'(evt_rov), 32'(m_rov));
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp1(logic [CNT_W-1:0] v);
        @(negedge clk);
        cmp1_val = v;
        cmp1_wr  = 1'b1;
        @(negedge clk);
        cmp1_wr  = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin : stim
        logic [CNT_W-1:0] hold;
        rst_n = 1'b0; run_en = 1'b0; restart_on_start = 1'b1; free_run = 1'b1;
        src_sel = 3'b001; presc = '0; cmp1_val = CNT_W'(MAXV); cmp2_val = 10'd700;
        cmp3_val = 10'd900; cmp1_wr = 1'b0; clr_req = 1'b0; src_strobe = 3'b000;
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        chk("reset count", 32'(count), 0);
        chk("reset events", 32'({evt_cmp, evt_rov}), 0);
        cmp_on = 1'b1;

        // R2: each valid source, then each invalid code
        tag = "R2";
        run_en = 1'b1;
        run(20);
        src_sel = 3'b010; run(20);
        src_sel = 3'b100; run(30);
        foreach (hold[i]) begin end
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2 || c == 4) continue;
            src_sel = 3'(c);
            @(negedge clk);
            hold = count;
            run(8);
            chk("held on invalid source R2", 32'(count), 32'(hold));
        end

        // R3: prescale division
        tag = "R3";
        src_sel = 3'b001; presc = 12'd3; run(60);
        presc = 12'd7; run(80);
        presc = 12'd0;

        // R6: coincident and separate matches
        tag = "R6";
        cmp2_val = count + 10'd15; cmp3_val = count + 10'd15; run(40);
        cmp2_val = count + 10'd9; cmp3_val = count + 10'd12; run(30);

        // R4: disable freezes
        tag = "R4";
        run_en = 1'b0;
        @(negedge clk);
        hold = count;
        run(10);
        chk("frozen count R4", 32'(count), 32'(hold));

        // R5: resume without restart, then restart on start
        tag = "R5";
        restart_on_start = 1'b0; run_en = 1'b1; run(15);
        run_en = 1'b0; run(2);
        restart_on_start = 1'b1; run_en = 1'b1;
        @(negedge clk);
        chk("start clears R5", 32'(count), 0);
        run(10);

        // R7: restart mode period
        tag = "R7";
        free_run = 1'b0;
        write_cmp1(10'd20);
        cmp2_val = 10'd20; cmp3_val = 10'd5;
        run(120);
        write_cmp1(10'd0);
        run(20);

        // R9: channel-1 write clears in restart mode only
        tag = "R9";
        write_cmp1(10'd12);
        chk("write clears R9", 32'(count), 0);
        run(50);
        free_run = 1'b1;
        run(25);
        write_cmp1(10'd30);
        run(30);

        // R8: free-run wrap, then restart mode at all-ones
        tag = "R8";
        cmp1_val = 10'd5; cmp2_val = 10'd0; cmp3_val = CNT_W'(MAXV);
        run(3200);
        free_run = 1'b0;
        write_cmp1(CNT_W'(MAXV));
        run(3200);
        free_run = 1'b1;

        // R10: clear requests override ticks
        tag = "R10";
        run(17);
        for (int k = 0; k < 4; k++) begin
            clr_req = 1'b1;
            @(negedge clk);
            clr_req = 1'b0;
            chk("clear R10", 32'(count), 0);
            run(9 + k);
        end
        run(5);

        cmp_on = 1'b0;
        finish_up();
    end

endmodule